// File: doc/BRIEF.md
# Two-Class Spatial Projection Multiply-Accumulate Unit

This block turns one multichannel sample frame into two spatially projected values. The frame arrives channel-serially, one sample per accepted clock. The first sample of a frame is flagged as channel 0. Each later valid sample is the next channel. Every sample is multiplied by two constant weights, one per projection class. The products are summed in two accumulators that run side by side. No sample is stored: each one is consumed in the cycle it is accepted.

When the last channel has been accepted, both sums are rounded to the signed 2.14 fixed-point format and saturated to it. They are then presented together with a one-cycle ready strobe for the variance stage that follows. The weight table is fixed at elaboration and is computed from a closed-form rule. There is no way to load weights.

Top module: `spatial_proj_mac`

## Requirements
- R1: While reset is held, and after it is released until the first frame completes, `out_ready` is 0 and both projections read 0.
- R2: The weight of class k (0 or 1) for channel c is (((c·M + A) mod 97) − 48)·256, interpreted as signed 2.14. For class 0, M = 53 and A = 3. For class 1, M = 29 and A = 7. A frame whose only nonzero sample is 16384 (1.0) on channel c yields exactly those two weights.
- R3: A valid sample with `in_start` high is taken as channel 0. It discards any earlier accumulation, so a frame that follows another with no idle cycle between them depends only on its own samples.
- R4: Inside a frame, each valid sample without `in_start` is the next channel. Cycles with `in_valid` low advance nothing, and their `in_data` has no effect.
- R5: In the cycle after channel N_CH−1 (58) is accepted, `out_ready` is 1 for exactly one cycle. At the same time `out_p0` and `out_p1` carry the projections Σ x[c]·w_k[c] of that frame.
- R6: The full-precision sum is converted to 2.14 by adding half an output LSB and then shifting right arithmetically, which rounds halves toward +∞. For example, −22.5 LSB becomes −22.
- R7: A rounded value above 32767 is output as 32767. A rounded value below −32768 is output as −32768. Neither wraps around.
- R8: Between ready strobes, both projections keep their last values.
- R9: Valid samples without `in_start` that arrive when no frame is open are ignored. They produce no strobe and change neither output nor any later frame.
- R10: A start sample in the middle of a frame abandons the partial frame. The new frame's result contains no contribution from the abandoned samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_data` carries a channel sample this cycle |
| in_start | input | 1 | With `in_valid`, marks the sample as channel 0 of a new frame |
| in_data | input | 16 | Filtered channel sample, signed 2.14 |
| out_ready | output | 1 | One-cycle strobe: both projections are new |
| out_p0 | output | 16 | Class-0 projection, signed 2.14, held between strobes |
| out_p1 | output | 16 | Class-1 projection, signed 2.14, held between strobes |

## Verification
The hardest behaviour to reach from the ports is the output quantiser at its edges. An exact rounding tie and a saturation in either direction each need a frame built around the signs and low-order bits of the fixed weights. The stimulus works these cases out from the weight rule. A lone value of 32 on channel 0 lands class 0 exactly on −22.5 LSB. A frame with full-scale samples whose signs match the weights drives the sum far past the 2.14 range, and flipping those signs drives it past the other end. Abandoned partial frames and stray samples between frames are also driven. After each, the next result is compared against a frame computed from scratch.

// File: rtl/spm_pkg.sv
// Shared constants and the closed-form weight rule for the spatial
// projection unit. Assumes weights fit in 16-bit signed 2.14.
package spm_pkg;

    localparam int N_CLS    = 2;
    localparam int W_MOD    = 97;
    localparam int W_BIAS   = 48;
    localparam int W_SCALE  = 256;

    // Multiplier and offset of the weight rule for a given class.
    function automatic int spm_mul(input int cls);
        return (cls == 0) ? 53 : 29;
    endfunction

    function automatic int spm_ofs(input int cls);
        return (cls == 0) ? 3 : 7;
    endfunction

    // Weight of class cls for channel ch, as a 2.14 integer.
    function automatic int spm_weight(input int cls, input int ch);
        return (((ch * spm_mul(cls) + spm_ofs(cls)) % W_MOD) - W_BIAS) * W_SCALE;
    endfunction

endpackage

// File: rtl/spm_weight_rom.sv
// Constant weight table for one projection class, indexed by channel.
// Assumes the index is below N_CH during use; padding entries read 0.
module spm_weight_rom #(
    parameter int N_CH = 59,
    parameter int DW   = 16,
    parameter int CW   = 6,
    parameter int CLS  = 0
) (
    input  logic [CW-1:0]        ch,
    output logic signed [DW-1:0] w
);

    localparam int DEPTH = 1 << CW;

    logic signed [DW-1:0] table_q [DEPTH];

    // One constant entry per addressable slot, computed from the rule.
    for (genvar c = 0; c < DEPTH; c++) begin : g_entry
        if (c < N_CH) begin : g_live
            localparam logic signed [DW-1:0] WV = DW'(spm_pkg::spm_weight(CLS, c));
            assign table_q[c] = WV;
        end else begin : g_pad
            assign table_q[c] = '0;
        end
    end

    // Combinational lookup of the selected channel's weight.
    assign w = table_q[ch];

endmodule

// File: rtl/spm_frame_ctrl.sv
// Frame sequencer: tracks whether a frame is open and which channel the
// current sample belongs to, and issues clear/accumulate/last controls.
// Assumes one sample per valid cycle; a start always opens a new frame.
module spm_frame_ctrl #(
    parameter int N_CH = 59,
    parameter int CW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    output logic [CW-1:0] ch_sel,
    output logic          acc_clear,
    output logic          acc_en,
    output logic          frame_last
);

    logic          busy;
    logic [CW-1:0] cnt;
    logic          accept;

    // Decode acceptance and the channel of the sample on the inputs now.
    always_comb begin
        accept     = in_valid && (in_start || busy);
        ch_sel     = in_start ? '0 : cnt;
        acc_clear  = in_valid && in_start;
        acc_en     = accept;
        frame_last = accept && (ch_sel == CW'(N_CH - 1));
    end

    // Advance the channel counter on each accepted sample; close on last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            if (frame_last) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                busy <= 1'b1;
                cnt  <= ch_sel + CW'(1);
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(N_CH)) else $error("channel counter out of range"); // R4
    AST_START_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start) |=> (cnt == CW'((N_CH > 1) ? 1 : 0))) else $error("start did not set channel 1 next"); // R3
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(cnt) && $stable(busy))) else $error("state moved on an idle cycle"); // R4

endmodule

// File: rtl/spm_mac_lane.sv
// One projection lane: multiplies the sample by its weight and keeps a
// guarded running sum. Assumes AW leaves room for N_CH full-scale products.
module spm_mac_lane #(
    parameter int DW = 16,
    parameter int AW = 39
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] w,
    input  logic                 clear,
    input  logic                 en,
    output logic signed [AW-1:0] acc_nxt
);

    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   prod_ext;
    logic signed [AW-1:0]   acc_q;

    // Full-precision product, sign-extended to the accumulator width.
    always_comb begin
        prod     = x * w;
        prod_ext = {{(AW - 2*DW){prod[2*DW-1]}}, prod};
        acc_nxt  = (clear ? '0 : acc_q) + prod_ext;
    end

    // Store the running sum on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/spm_round_sat.sv
// Converts a full-precision sum (2*FRAC fraction bits) to a DW-bit value
// with FRAC fraction bits: round half up, then clamp to the signed range.
module spm_round_sat #(
    parameter int AW   = 39,
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic signed [AW-1:0] acc,
    output logic signed [DW-1:0] q
);

    localparam logic signed [AW-1:0] HALF = {{(AW - FRAC){1'b0}}, 1'b1, {(FRAC - 1){1'b0}}};
    localparam logic signed [DW-1:0] QMAX = {1'b0, {(DW - 1){1'b1}}};
    localparam logic signed [DW-1:0] QMIN = {1'b1, {(DW - 1){1'b0}}};

    logic signed [AW-1:0] biased;
    logic signed [AW-1:0] shifted;
    logic                 ovf;

    // Round, detect loss of the upper bits, and clamp on overflow.
    always_comb begin
        biased  = acc + HALF;
        shifted = biased >>> FRAC;
        ovf     = (|shifted[AW-1:DW-1]) && !(&shifted[AW-1:DW-1]);
        if (ovf) begin
            q = shifted[AW-1] ? QMIN : QMAX;
        end else begin
            q = shifted[DW-1:0];
        end
    end

endmodule

// File: rtl/spatial_proj_mac.sv
// Top: channel-serial two-class spatial projection. Per class, a weight
// ROM, a MAC lane and an output quantiser; results are latched together
// with a one-cycle ready strobe when the last channel is accepted.
// Assumes N_CH >= 2 and inputs in signed 2.14 (FRAC fraction bits).
module spatial_proj_mac #(
    parameter int N_CH = 59,
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_start,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_ready,
    output logic signed [DW-1:0] out_p0,
    output logic signed [DW-1:0] out_p1
);

    localparam int N_CLS = spm_pkg::N_CLS;
    localparam int CW    = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int AW    = 2 * DW + $clog2(N_CH) + 1;

    logic [CW-1:0]        ch_sel;
    logic                 acc_clear;
    logic                 acc_en;
    logic                 frame_last;
    logic signed [AW-1:0] acc_nxt [N_CLS];
    logic signed [DW-1:0] q_val   [N_CLS];
    logic signed [DW-1:0] res_q   [N_CLS];

    spm_frame_ctrl #(
        .N_CH (N_CH),
        .CW   (CW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_start   (in_start),
        .ch_sel     (ch_sel),
        .acc_clear  (acc_clear),
        .acc_en     (acc_en),
        .frame_last (frame_last)
    );

    // One weight table, lane and quantiser per projection class.
    for (genvar k = 0; k < N_CLS; k++) begin : g_cls
        logic signed [DW-1:0] w_k;

        spm_weight_rom #(
            .N_CH (N_CH),
            .DW   (DW),
            .CW   (CW),
            .CLS  (k)
        ) u_rom (
            .ch (ch_sel),
            .w  (w_k)
        );

        spm_mac_lane #(
            .DW (DW),
            .AW (AW)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .x       (in_data),
            .w       (w_k),
            .clear   (acc_clear),
            .en      (acc_en),
            .acc_nxt (acc_nxt[k])
        );

        spm_round_sat #(
            .AW   (AW),
            .DW   (DW),
            .FRAC (FRAC)
        ) u_q (
            .acc (acc_nxt[k]),
            .q   (q_val[k])
        );
    end

    // Latch both quantised projections and raise ready on the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ready <= 1'b0;
            for (int k = 0; k < N_CLS; k++) begin
                res_q[k] <= '0;
            end
        end else begin
            out_ready <= frame_last;
            if (frame_last) begin
                for (int k = 0; k < N_CLS; k++) begin
                    res_q[k] <= q_val[k];
                end
            end
        end
    end

    assign out_p0 = res_q[0];
    assign out_p1 = res_q[1];

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |=> !out_ready) else $error("ready held longer than one cycle"); // R5
    AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> $past(in_valid)) else $error("ready without an accepted sample"); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> ($stable(out_p0) && $stable(out_p1))) else $error("projection changed without ready"); // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !$past(acc_nxt[0][AW-1])) |-> !out_p0[DW-1]) else $error("non-negative sum wrapped negative"); // R7

endmodule

// File: tb/sim_spatial_proj_mac.sv
// Scoreboard bench: the driver computes each frame's expected pair from
// the requirements and queues it; the monitor pops and compares on ready.
module sim_spatial_proj_mac;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 59;

    typedef int frame_t [N];
    typedef struct {
        int    e0;
        int    e1;
        string req;
    } exp_t;

    logic               clk;
    logic               rst_n;
    logic               in_valid;
    logic               in_start;
    logic signed [15:0] in_data;
    logic               out_ready;
    logic signed [15:0] out_p0;
    logic signed [15:0] out_p1;

    int   n_checks;
    int   n_errors;
    exp_t sb [$];
    int   last0;
    int   last1;
    bit   prev_ready;
    int   seed;

    spatial_proj_mac u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_data   (in_data),
        .out_ready (out_ready),
        .out_p0    (out_p0),
        .out_p1    (out_p1)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Weight per the stated rule, written independently of the design.
    function automatic int ref_w(input int k, input int c);
        int m;
        int a;
        m = (k == 0) ? 53 : 29;
        a = (k == 0) ? 3 : 7;
        return (((c * m + a) % 97) - 48) * 256;
    endfunction

    function automatic int ref_proj(input frame_t x, input int k);
        longint s;
        longint r;
        s = 0;
        for (int c = 0; c < N; c++) s += longint'(x[c]) * longint'(ref_w(k, c));
        r = (s + 64'sd8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // Drive n_drive samples of x; optional single idle gap before gap_at.
    task automatic drive_frame(input frame_t x, input int n_drive, input int gap_at,
                               input bit expect_out, input bit tail_idle, input string req);
        exp_t e;
        if (expect_out) begin
            e.e0 = ref_proj(x, 0);
            e.e1 = ref_proj(x, 1);
            e.req = req;
            sb.push_back(e);
        end
        for (int c = 0; c < n_drive; c++) begin
            if (c == gap_at) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_start = 1'b0;
                in_data  = 16'sh7abc;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (c == 0);
            in_data  = 16'(x[c]);
        end
        if (tail_idle) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_start = 1'b0;
            in_data  = '0;
        end
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic frame_t lcg_frame();
        frame_t f;
        for (int c = 0; c < N; c++) begin
            seed = seed * 1103515245 + 12345;
            f[c] = ((seed >>> 16) % 8001) - 4000;
        end
        return f;
    endfunction

    // Monitor: compares on ready, checks pulse width and holding between.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_ready) begin
                check(!prev_ready, "R5", "ready width", 2, 1);
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected ready", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(out_p0) == e.e0, e.req, "out_p0", int'(out_p0), e.e0);
                    check(int'(out_p1) == e.e1, e.req, "out_p1", int'(out_p1), e.e1);
                end
                last0 = int'(out_p0);
                last1 = int'(out_p1);
            end else begin
                check(int'(out_p0) == last0 && int'(out_p1) == last1, "R8", "hold p0",
                      int'(out_p0), last0);
            end
            prev_ready = out_ready;
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        frame_t f;
        frame_t z;
        n_checks = 0;
        n_errors = 0;
        last0 = 0;
        last1 = 0;
        prev_ready = 1'b0;
        seed = 7;
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_start = 1'b0;
        in_data = '0;
        for (int c = 0; c < N; c++) z[c] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_ready == 1'b0, "R1", "reset ready", int'(out_ready), 0);
        check(out_p0 == 16'sd0, "R1", "reset p0", int'(out_p0), 0);
        check(out_p1 == 16'sd0, "R1", "reset p1", int'(out_p1), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_ready == 1'b0 && out_p0 == 16'sd0, "R1", "idle after reset", int'(out_p0), 0);

        // R2: unit impulse on selected channels reads out the weights.
        foreach (f[c]) f[c] = 0;
        f[0] = 16384;
        drive_frame(f, N, -1, 1'b1, 1'b1, "R2");
        drain();
        check(int'(out_p0) == -11520, "R2", "weight c0 k0", int'(out_p0), -11520);
        check(int'(out_p1) == -10496, "R2", "weight c0 k1", int'(out_p1), -10496);
        foreach (f[c]) f[c] = 0;
        f[30] = 16384;
        drive_frame(f, N, -1, 1'b1, 1'b1, "R2");
        foreach (f[c]) f[c] = 0;
        f[58] = 16384;
        drive_frame(f, N, -1, 1'b1, 1'b1, "R2");
        drain();

        // R4/R5: pseudo-random frames, with an idle gap carrying junk data.
        f = lcg_frame();
        drive_frame(f, N, 17, 1'b1, 1'b1, "R4");
        f = lcg_frame();
        drive_frame(f, N, 40, 1'b1, 1'b1, "R5");
        drain();

        // R7: saturation high then low; R3: back-to-back frames, no idle.
        foreach (f[c]) f[c] = (ref_w(0, c) >= 0) ? 32767 : -32767;
        drive_frame(f, N, -1, 1'b1, 1'b0, "R7");
        f = lcg_frame();
        drive_frame(f, N, -1, 1'b1, 1'b1, "R3");
        drain();
        foreach (f[c]) f[c] = (ref_w(0, c) >= 0) ? 32767 : -32767;
        drive_frame(f, N, -1, 1'b1, 1'b1, "R7");
        drain();
        check(int'(out_p0) == 32767, "R7", "positive clamp", int'(out_p0), 32767);
        foreach (f[c]) f[c] = (ref_w(0, c) >= 0) ? -32767 : 32767;
        drive_frame(f, N, -1, 1'b1, 1'b1, "R7");
        drain();
        check(int'(out_p0) == -32768, "R7", "negative clamp", int'(out_p0), -32768);

        // R9: stray samples with no open frame change nothing.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = 1'b0;
            in_data  = 16'sh3fff;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_ready == 1'b0, "R9", "no strobe from strays", int'(out_ready), 0);
        check(int'(out_p0) == -32768, "R9", "output untouched", int'(out_p0), -32768);
        f = lcg_frame();
        drive_frame(f, N, -1, 1'b1, 1'b1, "R9");
        drain();

        // R6: exact half-LSB tie on class 0 rounds toward +inf.
        f = z;
        f[0] = 32;
        drive_frame(f, N, -1, 1'b1, 1'b1, "R6");
        drain();
        check(int'(out_p0) == -22, "R6", "tie round", int'(out_p0), -22);
        check(int'(out_p1) == -20, "R6", "tie round k1", int'(out_p1), -20);

        // R10: abandoned partial frame, then a restarted full frame.
        foreach (f[c]) f[c] = 30000;
        drive_frame(f, 25, -1, 1'b0, 1'b0, "R10");
        f = lcg_frame();
        drive_frame(f, N, -1, 1'b1, 1'b1, "R10");
        drain();

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R5", "all frames reported", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule